// File: doc/BRIEF.md
# Flash Write Protection Range Checker

This block sits in front of the program and erase engine of a serial flash array of 16 MB. The array takes 24-bit byte addresses and is divided into 256 blocks of 64 KB. Each block holds 16 sectors of 4 KB, and each sector holds pages of 256 bytes. For every program or erase request the block decides whether the operation may proceed. It returns the verdict one clock after the request strobe, together with a one-cycle valid pulse.

Two protection schemes are available, and a scheme-select input picks one. The range scheme protects a contiguous region anchored at the top or the bottom of the array. That region is sized in 64 KB blocks or 4 KB sectors from a 3-bit protect code, and a complement bit can invert it. The lock scheme ignores the range fields and consults one lock bit per 64 KB block. A single-write port sets or clears those lock bits. The configuration fields arrive as plain inputs that are held stable by the owner of the status registers.

Top module: `flash_wp_checker`

## Requirements
- R1: `rsp_valid` is high exactly one clock after each cycle in which `req_valid` is high, and only then. `rsp_allow` is 0 whenever `rsp_valid` is 0. Both outputs are 0 after reset.
- R2: In the range scheme (`cfg_lock_mode`=0), with `cfg_bp`=0 and `cfg_inv`=0, nothing is protected and every request is allowed.
- R3: With `cfg_fine`=0, a protect code n from 1 to 6 protects 2^(n-1) blocks of 64 KB. The code 7 protects the whole array.
- R4: With `cfg_fine`=1, a protect code n protects 2^(n-1) sectors of 4 KB, capped at 8 sectors (32 KB). Codes 4 to 7 therefore all protect 8 sectors.
- R5: With `cfg_from_bottom`=0, the protected region ends at the last byte 0xFFFFFF and grows down. With `cfg_from_bottom`=1, it starts at byte 0 and grows up.
- R6: With `cfg_inv`=1, the protected and unprotected regions set by the other range fields are swapped. In that mode `cfg_bp`=0 protects the whole array.
- R7: `req_op` encodes the operation as follows: 0 is a page program, 1 is a 4 KB sector erase, 2 is a 64 KB block erase, and 3 is a chip erase. A sector or block erase is denied if any sector of the aligned region that contains `req_addr` is protected. A program is judged by the sector of `req_addr`.
- R8: In the range scheme, a chip erase is denied if any part of the array is protected.
- R9: With `cfg_lock_mode`=1, the range fields have no effect. A program, sector erase or block erase is denied exactly when the lock bit of the block `req_addr[23:16]` is 1.
- R10: When `lock_we` is high, the lock bit of block `lock_blk` takes the value `lock_val` at that clock edge. Requests sampled in later cycles see the new value. Reset clears all lock bits to 0.
- R11: With `cfg_lock_mode`=1, a chip erase is denied if any lock bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation: 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | 24 | Target byte address |
| cfg_bp | input | 3 | Protect size code |
| cfg_from_bottom | input | 1 | 0: region anchored at top, 1: at bottom |
| cfg_fine | input | 1 | 0: 64 KB units, 1: 4 KB units |
| cfg_inv | input | 1 | Invert the protected region |
| cfg_lock_mode | input | 1 | 0: range scheme, 1: per-block locks |
| lock_we | input | 1 | Lock bit write strobe |
| lock_blk | input | 8 | Block whose lock bit is written |
| lock_val | input | 1 | Value written to the lock bit |
| rsp_valid | output | 1 | Verdict valid pulse |
| rsp_allow | output | 1 | 1: operation allowed, 0: denied |

## Verification
The bench probes the first unprotected byte and the last protected byte on each edge of the region. It does this for both anchors, for several codes in both granularities, and for the capped fine codes. An off-by-one in the size or the anchor shows up there as a flipped verdict. Erases that straddle a protected sector catch a design that judges only the addressed sector. The empty and the full regions under inversion catch a design that inverts an empty range into nothing. In lock mode, the bench sets a lock bit, clears it again, and issues chip erases. This exposes a lock write that lands too late, a scheme select that still consults the range fields, and a chip erase that ignores a lock held on a single block.

// File: rtl/flash_wp_pkg.sv
// Package: shared operation codes and array geometry for the write
// protection checker. Assumes a power-of-two array of blocks and sectors.
package flash_wp_pkg;

    // Operation codes carried on req_op
    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_SERASE = 2'd1,
        OP_BERASE = 2'd2,
        OP_CHIP   = 2'd3
    } wp_op_e;

endpackage

// File: rtl/wp_range_decode.sv
// Module: turns the range-scheme fields into an inclusive span of protected
// sector indices plus a non-empty flag. Pure combinational.
// Assumes: code 0 means empty; coarse all-ones code covers the whole array;
// fine sizes are capped at 2^FINE_CAP_LOG sectors.
module wp_range_decode #(
    parameter int BP_W         = 3,
    parameter int SIDX_W       = 12,
    parameter int SIB_W        = 4,
    parameter int FINE_CAP_LOG = 3
) (
    input  logic [BP_W-1:0]   cfg_bp,
    input  logic              cfg_from_bottom,
    input  logic              cfg_fine,
    output logic              prot_any,
    output logic [SIDX_W-1:0] prot_lo,
    output logic [SIDX_W-1:0] prot_hi
);
    localparam logic [SIDX_W:0] NSEC = (SIDX_W+1)'(1) << SIDX_W;

    logic [SIDX_W:0] size;
    logic [SIDX_W:0] lo_w;
    logic [SIDX_W:0] hi_w;
    int              shamt;

    // Size of the protected region, counted in sectors
    always_comb begin
        size  = '0;
        shamt = 0;
        if (cfg_bp != '0) begin
            if (!cfg_fine) begin
                shamt = int'(cfg_bp) - 1 + SIB_W;
                if (cfg_bp == '1 || shamt >= SIDX_W) size = NSEC;
                else                                 size = (SIDX_W+1)'(1) << shamt;
            end else begin
                shamt = int'(cfg_bp) - 1;
                if (shamt > FINE_CAP_LOG) shamt = FINE_CAP_LOG;
                size = (SIDX_W+1)'(1) << shamt;
            end
        end
    end

    // Anchor the span at the bottom or top of the array
    always_comb begin
        if (cfg_from_bottom) begin
            lo_w = '0;
            hi_w = size - (SIDX_W+1)'(1);
        end else begin
            lo_w = NSEC - size;
            hi_w = NSEC - (SIDX_W+1)'(1);
        end
    end

    assign prot_any = (size != '0);
    assign prot_lo  = lo_w[SIDX_W-1:0];
    assign prot_hi  = hi_w[SIDX_W-1:0];

endmodule

// File: rtl/wp_target_span.sv
// Module: converts an operation and the sector index of its address into
// the inclusive span of sector indices the operation touches.
// Assumes a page never crosses a sector, so a program touches one sector.
module wp_target_span
    import flash_wp_pkg::*;
#(
    parameter int SIDX_W = 12,
    parameter int SIB_W  = 4
) (
    input  wp_op_e            op,
    input  logic [SIDX_W-1:0] sidx,
    output logic [SIDX_W-1:0] tgt_lo,
    output logic [SIDX_W-1:0] tgt_hi
);
    localparam int BLK_W = SIDX_W - SIB_W;

    // Select the region covered by each operation type
    always_comb begin
        unique case (op)
            OP_PROG, OP_SERASE: begin
                tgt_lo = sidx;
                tgt_hi = sidx;
            end
            OP_BERASE: begin
                tgt_lo = {sidx[SIDX_W-1 -: BLK_W], {SIB_W{1'b0}}};
                tgt_hi = {sidx[SIDX_W-1 -: BLK_W], {SIB_W{1'b1}}};
            end
            default: begin
                tgt_lo = '0;
                tgt_hi = '1;
            end
        endcase
    end

endmodule

// File: rtl/wp_lock_array.sv
// Module: one lock flop per block, written one bit at a time, with a read
// port for a single block and an any-set summary.
// Assumes synchronous active-low reset clears every lock.
module wp_lock_array #(
    parameter int BLK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_we,
    input  logic [BLK_W-1:0] lock_blk,
    input  logic             lock_val,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_locked,
    output logic             any_locked
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] lock_q;

    for (genvar b = 0; b < NBLK; b++) begin : g_lock
        // Hold or update the lock bit of block b
        always_ff @(posedge clk) begin
            if (!rst_n)                                 lock_q[b] <= 1'b0;
            else if (lock_we && lock_blk == BLK_W'(b))  lock_q[b] <= lock_val;
        end
    end

    assign rd_locked  = lock_q[rd_blk];
    assign any_locked = |lock_q;

endmodule

// File: rtl/flash_wp_checker.sv
// Module: top of the write protection checker. Combines the range decoder,
// the target span and the lock array into a deny decision, registered one
// clock after the request strobe.
// Assumes configuration inputs are stable around each request.
module flash_wp_checker
    import flash_wp_pkg::*;
#(
    parameter int BLK_W        = 8,
    parameter int SIB_W        = 4,
    parameter int OFS_W        = 12,
    parameter int BP_W         = 3,
    parameter int FINE_CAP_LOG = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [1:0]                      req_op,
    input  logic [BLK_W+SIB_W+OFS_W-1:0]    req_addr,
    input  logic [BP_W-1:0]                 cfg_bp,
    input  logic                            cfg_from_bottom,
    input  logic                            cfg_fine,
    input  logic                            cfg_inv,
    input  logic                            cfg_lock_mode,
    input  logic                            lock_we,
    input  logic [BLK_W-1:0]                lock_blk,
    input  logic                            lock_val,
    output logic                            rsp_valid,
    output logic                            rsp_allow
);
    localparam int SIDX_W = BLK_W + SIB_W;
    localparam int ADDR_W = SIDX_W + OFS_W;

    wp_op_e            op;
    logic [SIDX_W-1:0] sidx;
    logic [SIDX_W-1:0] prot_lo, prot_hi, tgt_lo, tgt_hi;
    logic              prot_any;
    logic              rd_locked, any_locked;
    logic              range_hit, lock_hit, deny;
    logic              addr_ofs_unused;

    assign op              = wp_op_e'(req_op);
    assign sidx            = req_addr[ADDR_W-1:OFS_W];
    assign addr_ofs_unused = ^req_addr[OFS_W-1:0];

    wp_range_decode #(
        .BP_W(BP_W), .SIDX_W(SIDX_W), .SIB_W(SIB_W), .FINE_CAP_LOG(FINE_CAP_LOG)
    ) u_range (
        .cfg_bp          (cfg_bp),
        .cfg_from_bottom (cfg_from_bottom),
        .cfg_fine        (cfg_fine),
        .prot_any        (prot_any),
        .prot_lo         (prot_lo),
        .prot_hi         (prot_hi)
    );

    wp_target_span #(.SIDX_W(SIDX_W), .SIB_W(SIB_W)) u_span (
        .op     (op),
        .sidx   (sidx),
        .tgt_lo (tgt_lo),
        .tgt_hi (tgt_hi)
    );

    wp_lock_array #(.BLK_W(BLK_W)) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_we    (lock_we),
        .lock_blk   (lock_blk),
        .lock_val   (lock_val),
        .rd_blk     (sidx[SIDX_W-1 -: BLK_W]),
        .rd_locked  (rd_locked),
        .any_locked (any_locked)
    );

    // Range scheme: overlap with the span, or not fully inside it when inverted
    always_comb begin
        if (cfg_inv)
            range_hit = !(prot_any && tgt_lo >= prot_lo && tgt_hi <= prot_hi);
        else
            range_hit = prot_any && !(tgt_hi < prot_lo || tgt_lo > prot_hi);
    end

    // Lock scheme: chip erase checks every block, others their own block
    assign lock_hit = (op == OP_CHIP) ? any_locked : rd_locked;
    assign deny     = cfg_lock_mode ? lock_hit : range_hit;

    // Register the verdict and its valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_allow <= req_valid && !deny;
        end
    end

endmodule

// File: rtl/flash_wp_sva.sv
// Checker: temporal properties of the write protection checker, bound to
// the top module. Observes ports plus the lock array summary.
module flash_wp_sva #(
    parameter int BP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [BP_W-1:0] cfg_bp,
    input logic            cfg_fine,
    input logic            cfg_inv,
    input logic            cfg_lock_mode,
    input logic            any_locked,
    input logic            rsp_valid,
    input logic            rsp_allow
);
    // R1: a verdict follows each request one clock later
    p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1: no verdict without a request
    p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1: allow only qualified by valid
    p_allow_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_allow);

    // R2: empty region allows everything
    p_empty_allows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_lock_mode && cfg_bp == '0 && !cfg_inv) |=> rsp_allow);

    // R3: coarse all-ones code denies everything
    p_full_denies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_lock_mode && cfg_bp == '1 && !cfg_fine && !cfg_inv) |=> !rsp_allow);

    // R6: inverted empty region denies everything
    p_inv_empty_denies_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_lock_mode && cfg_bp == '0 && cfg_inv) |=> !rsp_allow);

    // R11: chip erase with any lock held is denied
    p_chip_lock_denies_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_lock_mode && req_op == 2'd3 && any_locked) |=> !rsp_allow);

endmodule

bind flash_wp_checker flash_wp_sva #(.BP_W(BP_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .cfg_bp        (cfg_bp),
    .cfg_fine      (cfg_fine),
    .cfg_inv       (cfg_inv),
    .cfg_lock_mode (cfg_lock_mode),
    .any_locked    (any_locked),
    .rsp_valid     (rsp_valid),
    .rsp_allow     (rsp_allow)
);

// File: tb/tb_flash_wp_checker.sv
module tb_flash_wp_checker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [23:0] req_addr = '0;
    logic [2:0]  cfg_bp = '0;
    logic        cfg_from_bottom = 1'b0;
    logic        cfg_fine = 1'b0;
    logic        cfg_inv = 1'b0;
    logic        cfg_lock_mode = 1'b0;
    logic        lock_we = 1'b0;
    logic [7:0]  lock_blk = '0;
    logic        lock_val = 1'b0;
    logic        rsp_valid, rsp_allow;

    int tests = 0;
    int fails = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_wp_checker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .cfg_bp(cfg_bp), .cfg_from_bottom(cfg_from_bottom),
        .cfg_fine(cfg_fine), .cfg_inv(cfg_inv), .cfg_lock_mode(cfg_lock_mode),
        .lock_we(lock_we), .lock_blk(lock_blk), .lock_val(lock_val),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every verdict, flags stray outputs
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) check("R1 unexpected rsp_valid", 1'b1, 1'b0);
                else check(tag_q.pop_front(), rsp_allow, exp_q.pop_front());
            end else if (rsp_allow) begin
                check("R1 allow without valid", rsp_allow, 1'b0);
            end
        end
    end

    task automatic set_cfg(input logic [2:0] bp, input logic bot, input logic fine,
                           input logic inv, input logic lm);
        cfg_bp = bp; cfg_from_bottom = bot; cfg_fine = fine;
        cfg_inv = inv; cfg_lock_mode = lm;
    endtask

    // Driver: one-cycle request strobe, expected verdict queued
    task automatic issue(input logic [1:0] op, input logic [23:0] addr,
                         input bit exp_allow, input string tag);
        req_op = op; req_addr = addr; req_valid = 1'b1;
        exp_q.push_back(exp_allow); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic set_lock(input logic [7:0] blk, input logic val);
        lock_blk = blk; lock_val = val; lock_we = 1'b1;
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check("watchdog expired", 1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", rsp_valid, 1'b0);
        check("R1 reset rsp_allow", rsp_allow, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 and R8: nothing protected
        set_cfg(3'd0, 0, 0, 0, 0);
        issue(2'd0, 24'h123456, 1, "R2 program empty region");
        issue(2'd3, 24'h000000, 1, "R8 chip erase empty region");

        // R3 / R5 top anchored, coarse
        set_cfg(3'd1, 0, 0, 0, 0);
        issue(2'd0, 24'hFF0000, 0, "R3 code1 block255");
        issue(2'd0, 24'hFEFFFF, 1, "R3 code1 block254");
        set_cfg(3'd3, 0, 0, 0, 0);
        issue(2'd0, 24'hFC0000, 0, "R3 code3 block252");
        issue(2'd0, 24'hFBFFFF, 1, "R3 code3 block251");
        set_cfg(3'd6, 0, 0, 0, 0);
        issue(2'd0, 24'hE00000, 0, "R3 code6 block224");
        issue(2'd0, 24'hDFFFFF, 1, "R3 code6 block223");
        set_cfg(3'd7, 0, 0, 0, 0);
        issue(2'd0, 24'h000000, 0, "R3 code7 whole array");

        // R5 bottom anchored
        set_cfg(3'd2, 1, 0, 0, 0);
        issue(2'd0, 24'h01FFFF, 0, "R5 bottom code2 block1");
        issue(2'd0, 24'h020000, 1, "R5 bottom code2 block2");
        issue(2'd0, 24'hFF0000, 1, "R5 bottom code2 top block");

        // R4 fine granularity
        set_cfg(3'd1, 0, 1, 0, 0);
        issue(2'd0, 24'hFFF000, 0, "R4 fine code1 last sector");
        issue(2'd0, 24'hFFEFFF, 1, "R4 fine code1 next sector");
        set_cfg(3'd4, 0, 1, 0, 0);
        issue(2'd0, 24'hFF8000, 0, "R4 fine code4 edge in");
        issue(2'd0, 24'hFF7FFF, 1, "R4 fine code4 edge out");
        set_cfg(3'd7, 0, 1, 0, 0);
        issue(2'd0, 24'hFF8000, 0, "R4 fine code7 capped in");
        issue(2'd0, 24'hFF7FFF, 1, "R4 fine code7 capped out");
        set_cfg(3'd3, 1, 1, 0, 0);
        issue(2'd0, 24'h003FFF, 0, "R4 fine bottom code3 in");
        issue(2'd0, 24'h004000, 1, "R4 fine bottom code3 out");

        // R6 complement
        set_cfg(3'd1, 0, 0, 1, 0);
        issue(2'd0, 24'hFF0000, 1, "R6 inv code1 block255");
        issue(2'd0, 24'hFEFFFF, 0, "R6 inv code1 block254");
        set_cfg(3'd0, 0, 0, 1, 0);
        issue(2'd0, 24'h123456, 0, "R6 inv empty is full");
        set_cfg(3'd7, 0, 0, 1, 0);
        issue(2'd3, 24'h000000, 1, "R6 inv full is empty chip erase");

        // R7 erase spans, R8 chip erase
        set_cfg(3'd1, 0, 1, 0, 0);
        issue(2'd2, 24'hFF1234, 0, "R7 block erase overlaps last sector");
        issue(2'd1, 24'hFF1234, 1, "R7 sector erase clear sector");
        issue(2'd2, 24'hFE0000, 1, "R7 block erase clear block");
        issue(2'd3, 24'h000000, 0, "R8 chip erase partial protect");
        set_cfg(3'd1, 0, 1, 1, 0);
        issue(2'd1, 24'hFFF000, 1, "R7 inv sector erase free sector");
        issue(2'd2, 24'hFF0000, 0, "R7 inv block erase straddles");

        // R9 and R10: lock scheme, range ignored, reset state unlocked
        set_cfg(3'd7, 0, 0, 0, 1);
        issue(2'd0, 24'h000000, 1, "R9 R10 range ignored, unlocked at reset");
        set_lock(8'd5, 1'b1);
        issue(2'd0, 24'h050000, 0, "R10 locked block5 program");
        issue(2'd0, 24'h060000, 1, "R9 unlocked block6 program");
        issue(2'd1, 24'h05F000, 0, "R9 locked block5 sector erase");
        issue(2'd2, 24'h04FFFF, 1, "R9 block4 erase");
        set_lock(8'd5, 1'b0);
        issue(2'd0, 24'h050000, 1, "R10 cleared block5 program");

        // R11 chip erase under locks
        set_lock(8'd200, 1'b1);
        issue(2'd3, 24'h000000, 0, "R11 chip erase with lock");
        set_lock(8'd200, 1'b0);
        issue(2'd3, 24'h000000, 1, "R11 chip erase no lock");

        repeat (3) @(negedge clk);
        check("R1 all verdicts delivered", exp_q.size() == 0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule